// File: doc/BRIEF.md
# Two-Way Write-Back Byte Cache

This block is a small data cache that sits between a CPU byte port and a main-memory port that is one 32-bit word wide. It holds eight one-word lines, arranged as four sets of two ways. Each CPU byte address is split into a tag, a set number and a byte offset. Both ways of the selected set are checked in the same cycle, and a hit is served at once. A read hit returns the addressed byte. A write hit merges the byte into the cached word and marks the line modified.

On a miss the cache stalls the CPU and chooses a victim way. An empty way is taken first. When both ways are full, the way named by the set's least-recently-used bit is replaced. A modified victim is first written back to memory. The missing word is then read from memory and installed, and the CPU access is retried internally, so it now hits and completes.

The CPU keeps its request and its address, write flag and write byte unchanged until it sees the ready signal high while requesting. The access completes on the clock edge that follows. Memory requests stay up, with address, direction and data unchanged, until a one-cycle acknowledge arrives.

Top module: `wb_cache2`

## Requirements
- R1: The byte address is decoded as follows: bits [1:0] select the byte within the word, bits [3:2] select one of four sets, and bits [31:4] are the tag. Memory is always addressed as a whole word, {tag, set, 2'b00}.
- R2: A hit needs a valid line in the selected set whose stored tag equals the address tag. On a read hit, `cpu_ready` is high in the request cycle, `cpu_rdata` carries the byte chosen by the offset, and no memory transaction is made.
- R3: A write hit replaces only the addressed byte of the cached word, marks the line modified, and makes no memory write.
- R4: On a miss, `cpu_ready` is low in the request cycle and stays low until the line has been installed and the access completes.
- R5: On a miss the victim is way 0 if way 0 is empty, otherwise way 1 if way 1 is empty, otherwise the way named by the set's use bit.
- R6: Every completed access sets the use bit of its set to name the other way (0 means way 0 is least recently used).
- R7: A modified victim is written to memory at {victim tag, set, 2'b00} before the refill read is issued. A clean victim causes no memory write.
- R8: A write miss first reads the line from memory, then merges the byte into the cache and marks the line modified, without any immediate memory write. A refill for a read miss leaves the line clean.
- R9: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack`. One acknowledge cycle ends one transaction, and exactly one transaction is made per refill or write-back.
- R10: Reset (`rst_n` low at a clock edge) clears every valid, modified and use bit. After reset `cpu_ready` is high when idle, `mem_req` is low, and modified data held before the reset is never written back.
- R11: Reads of 0x04, then 0x24, then 0x54 leave 0x54 in way 0 of set 1 with the use bit naming way 1. A following read of 0x04 therefore evicts 0x24, and 0x54 still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until accepted |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_ready | output | 1 | High when idle or when the held request hits and completes at the next edge |
| cpu_rdata | output | 8 | Byte read on a hit |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Word address of the transaction |
| mem_wdata | output | 32 | Victim word being written back |
| mem_rdata | input | 32 | Refill word, valid while `mem_ack` is high |
| mem_ack | input | 1 | One-cycle transaction acknowledge |

## Verification
The bench targets replacement order within one set. If the empty-way priority or the use-bit sense were wrong, a line that should still be resident would be evicted, and the count of memory reads would show the extra refill. It also forces a modified victim out, then reads back the written byte and a neighbouring byte through a fresh refill. A design that skipped the write-back, used the new tag as the write-back address, or dropped the merge on a write miss would return the original memory byte. Finally, a reset is applied while a modified line is held. A design that left valid or modified bits set would hit without any memory read or would write back the stale line.

// File: rtl/cache_pkg.sv
// Shared sizes and the controller state type for the two-way byte cache.
// Assumes a power-of-two set count and word size; two ways are fixed by the
// single-bit use tracking.
package cache_pkg;
    parameter int ADDR_W     = 32;
    parameter int SETS       = 4;
    parameter int WAYS       = 2;
    parameter int WORD_BYTES = 4;

    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int WORD_W = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WBACK  = 2'd1,
        ST_REFILL = 2'd2
    } cstate_t;
endpackage

// File: rtl/cache_store.sv
// Line storage: tags, data words, valid/modified bits and one use bit per set.
// Provides the parallel lookup of both ways, victim choice, and read-out of
// a selected way for write-back. Assumes a fill and a CPU access never
// occur in the same cycle.
module cache_store
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [WAYS-1:0]   hit_o,
    output logic [WORD_W-1:0] hit_word_o,
    output logic              vict_way_o,
    output logic              vict_valid_o,
    output logic              vict_dirty_o,
    input  logic              sel_way_i,
    output logic [TAG_W-1:0]  line_tag_o,
    output logic [WORD_W-1:0] line_data_o,
    input  logic              fill_en_i,
    input  logic [WORD_W-1:0] fill_data_i,
    input  logic              acc_en_i,
    input  logic              acc_we_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [7:0]        wbyte_i
);
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [WORD_W-1:0] data_q [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [SETS-1:0][WAYS-1:0] dirty_q;
    logic [SETS-1:0]           use_q;

    logic acc_way;

    // Per-way tag comparison of the selected set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_o[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    end

    assign acc_way    = hit_o[1];
    assign hit_word_o = data_q[set_i][acc_way];

    // Victim choice: empty way 0, then empty way 1, then the LRU way.
    always_comb begin
        if (!valid_q[set_i][0])      vict_way_o = 1'b0;
        else if (!valid_q[set_i][1]) vict_way_o = 1'b1;
        else                         vict_way_o = use_q[set_i];
    end

    assign vict_valid_o = valid_q[set_i][vict_way_o];
    assign vict_dirty_o = dirty_q[set_i][vict_way_o];
    assign line_tag_o   = tag_q[set_i][sel_way_i];
    assign line_data_o  = data_q[set_i][sel_way_i];

    // Status bits: cleared by reset, set by fills and accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            use_q   <= '0;
        end else if (fill_en_i) begin
            valid_q[set_i][sel_way_i] <= 1'b1;
            dirty_q[set_i][sel_way_i] <= 1'b0;
        end else if (acc_en_i) begin
            use_q[set_i] <= ~acc_way;
            if (acc_we_i) dirty_q[set_i][acc_way] <= 1'b1;
        end
    end

    // Tag and data payload: loaded on fill, byte-merged on a write hit.
    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            tag_q[set_i][sel_way_i]  <= tag_i;
            data_q[set_i][sel_way_i] <= fill_data_i;
        end else if (acc_en_i && acc_we_i) begin
            data_q[set_i][acc_way][off_i*8 +: 8] <= wbyte_i;
        end
    end

    // R2: the two ways of a set never hold the same valid tag.
    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));
endmodule

// File: rtl/cache_ctrl.sv
// Miss sequencer: idles while the CPU hits; on a miss latches the victim way,
// optionally writes it back, then refills it and returns to idle, where the
// held CPU request hits. Assumes the CPU holds its request stable while
// ready is low, and that memory acknowledges with a single-cycle pulse.
module cache_ctrl
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req_i,
    input  logic hit_any_i,
    input  logic vict_way_i,
    input  logic vict_valid_i,
    input  logic vict_dirty_i,
    input  logic mem_ack_i,
    output logic cpu_ready_o,
    output logic acc_en_o,
    output logic fill_en_o,
    output logic way_o,
    output logic mem_req_o,
    output logic mem_we_o
);
    cstate_t state_q;
    logic    way_q;

    // State register and victim-way latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            way_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_req_i && !hit_any_i) begin
                    way_q   <= vict_way_i;
                    state_q <= (vict_valid_i && vict_dirty_i) ? ST_WBACK : ST_REFILL;
                end
                ST_WBACK:  if (mem_ack_i) state_q <= ST_REFILL;
                ST_REFILL: if (mem_ack_i) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the state.
    assign cpu_ready_o = (state_q == ST_IDLE) && (!cpu_req_i || hit_any_i);
    assign acc_en_o    = (state_q == ST_IDLE) && cpu_req_i && hit_any_i;
    assign fill_en_o   = (state_q == ST_REFILL) && mem_ack_i;
    assign mem_req_o   = (state_q != ST_IDLE);
    assign mem_we_o    = (state_q == ST_WBACK);
    assign way_o       = way_q;

    // R9: a memory request is held until it is acknowledged.
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o);

    // R4: a miss seen in idle stalls the CPU in the next cycle.
    p_miss_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req_i && !hit_any_i) |=> !cpu_ready_o);

    // R7: a finished write-back is followed by a refill read.
    p_wb_then_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));
endmodule

// File: rtl/wb_cache2.sv
// Top of the two-way write-back, write-allocate byte cache. Splits the CPU
// address, connects lookup storage to the miss sequencer, and forms the
// memory word address. Assumes the CPU holds address, write flag and byte
// stable while ready is low.
module wb_cache2
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ready,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [OFF_W-1:0]  off;
    logic [SET_W-1:0]  set;
    logic [TAG_W-1:0]  tag;
    logic [WAYS-1:0]   hit;
    logic [WORD_W-1:0] hit_word, line_data;
    logic [TAG_W-1:0]  line_tag;
    logic vict_way, vict_valid, vict_dirty, way, acc_en, fill_en;

    assign off = cpu_addr[OFF_W-1:0];
    assign set = cpu_addr[OFF_W +: SET_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    cache_store u_store (
        .clk(clk), .rst_n(rst_n), .set_i(set), .tag_i(tag),
        .hit_o(hit), .hit_word_o(hit_word),
        .vict_way_o(vict_way), .vict_valid_o(vict_valid), .vict_dirty_o(vict_dirty),
        .sel_way_i(way), .line_tag_o(line_tag), .line_data_o(line_data),
        .fill_en_i(fill_en), .fill_data_i(mem_rdata),
        .acc_en_i(acc_en), .acc_we_i(cpu_we), .off_i(off), .wbyte_i(cpu_wdata)
    );

    cache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req), .hit_any_i(|hit),
        .vict_way_i(vict_way), .vict_valid_i(vict_valid), .vict_dirty_i(vict_dirty),
        .mem_ack_i(mem_ack), .cpu_ready_o(cpu_ready), .acc_en_o(acc_en),
        .fill_en_o(fill_en), .way_o(way), .mem_req_o(mem_req), .mem_we_o(mem_we)
    );

    // Byte select of the hit word and word address of the memory transaction.
    assign cpu_rdata = hit_word[off*8 +: 8];
    assign mem_addr  = mem_we ? {line_tag, set, {OFF_W{1'b0}}}
                              : {tag, set, {OFF_W{1'b0}}};
    assign mem_wdata = line_data;

    // R9: transaction fields stay put while waiting for the acknowledge.
    p_fields_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R1: memory is only ever addressed by whole words.
    p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/tb_wb_cache2.sv
`timescale 1ns/1ps
module tb_wb_cache2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, fails = 0, cycles = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [1:0]  dly = '0;
    logic [31:0] mem [256];
    logic [7:0]  ref_b [1024];

    wb_cache2 dut (.*);

    always #4 clk = ~clk;

    // Memory model: acknowledges each request after a short wait.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (dly == 2'd2) begin
                dly <= '0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                    rd_cnt <= rd_cnt + 1;
                end
            end else dly <= dly + 2'd1;
        end else dly <= '0;
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_acc(input logic we, input logic [31:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output logic first_rdy,
                          output int nr, output int nw);
        int r0, w0;
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        #1;
        first_rdy = cpu_ready;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        nr = rd_cnt - r0;
        nw = wr_cnt - w0;
    endtask

    // Vector: we[24], addr[23:12], wdata[11:4], reads[3:2], writes[1:0].
    localparam int NV = 18;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 12'h004, 8'h00, 2'd1, 2'd0},  // set1 way0 fill (R5)
        {1'b0, 12'h024, 8'h00, 2'd1, 2'd0},  // set1 way1 fill (R5)
        {1'b0, 12'h054, 8'h00, 2'd1, 2'd0},  // evicts 0x04 in way0 (R11)
        {1'b0, 12'h004, 8'h00, 2'd1, 2'd0},  // evicts 0x24 in way1 (R11)
        {1'b0, 12'h054, 8'h00, 2'd0, 2'd0},  // hit (R11)
        {1'b0, 12'h024, 8'h00, 2'd1, 2'd0},  // evicts 0x04 (R6)
        {1'b1, 12'h025, 8'hAB, 2'd0, 2'd0},  // write hit (R3)
        {1'b0, 12'h025, 8'h00, 2'd0, 2'd0},  // read back merged byte (R3)
        {1'b0, 12'h014, 8'h00, 2'd1, 2'd0},  // evicts clean 0x54 (R7)
        {1'b0, 12'h034, 8'h00, 2'd1, 2'd1},  // evicts dirty 0x24 (R7)
        {1'b0, 12'h026, 8'h00, 2'd1, 2'd0},  // refill written-back word (R7)
        {1'b0, 12'h025, 8'h00, 2'd0, 2'd0},  // hit, written byte (R7)
        {1'b1, 12'h048, 8'h11, 2'd1, 2'd0},  // write miss allocate (R8)
        {1'b1, 12'h049, 8'h22, 2'd0, 2'd0},  // write hit (R3)
        {1'b0, 12'h088, 8'h00, 2'd1, 2'd0},  // set2 way1 fill (R5)
        {1'b0, 12'h0C8, 8'h00, 2'd1, 2'd1},  // evicts dirty 0x48 (R8)
        {1'b0, 12'h049, 8'h00, 2'd1, 2'd0},  // refill holds 0x22 (R8)
        {1'b0, 12'h048, 8'h00, 2'd0, 2'd0}   // hit holds 0x11 (R8)
    };

    initial begin
        logic [7:0] rd;
        logic       fr;
        int         nr, nw;
        for (int i = 0; i < 1024; i++) ref_b[i] = 8'(i) ^ 8'h3C;
        for (int i = 0; i < 256; i++)
            mem[i] = {ref_b[4*i+3], ref_b[4*i+2], ref_b[4*i+1], ref_b[4*i]};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle ready after reset", 32'(cpu_ready), 32'd1);
        check("R10 no memory request after reset", 32'(mem_req), 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic        we;
            logic [31:0] a;
            logic [7:0]  wd;
            we = VEC[v][24];
            a  = {20'd0, VEC[v][23:12]};
            wd = VEC[v][11:4];
            do_acc(we, a, wd, rd, fr, nr, nw);
            if (!we) check("R1/R2/R3/R7/R8 read byte", 32'(rd), 32'(ref_b[a[9:0]]));
            else ref_b[a[9:0]] = wd;
            check("R5/R6/R9/R11 memory reads", 32'(nr), 32'(VEC[v][3:2]));
            check("R7/R8/R9 memory writes", 32'(nw), 32'(VEC[v][1:0]));
            check("R2/R4 ready in request cycle", 32'(fr), (VEC[v][3:2] == 2'd0) ? 32'd1 : 32'd0);
        end

        // R10: dirty line held across a reset is discarded, lines are invalid.
        do_acc(1'b1, 32'h0000_0049, 8'h77, rd, fr, nr, nw);   // 0x49 is resident: hit
        check("R3 write hit without traffic", 32'(nr + nw), 32'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_acc(1'b0, 32'h0000_0049, 8'h00, rd, fr, nr, nw);
        check("R10 miss after reset", 32'(nr), 32'd1);
        check("R10 no write-back of pre-reset data", 32'(nw), 32'd0);
        check("R10 data from memory", 32'(rd), 32'(ref_b[10'h049]));
        check("R4 stall after reset miss", 32'(fr), 32'd0);

        finish_run();
    end
endmodule